// File: doc/BRIEF.md
# Transmit DMA Engine with Base and Count Registers

This block moves a run of bytes from memory to a network transmitter without the processor touching each byte. Software writes a start address and a byte count into two registers, clears any old completion interrupt, and then writes a go register. The engine then reads memory one byte at a time through a simple master read port and hands each byte to the transmit side over a valid/ready link. Once the last byte has been taken, it raises an interrupt that stays high until software acknowledges it.

Setup therefore takes four register stores: address, count, acknowledge, go. The address and count registers are also the working registers. Each byte the transmitter accepts moves the address up by one and the count down by one, so software can read the progress at any time. Writes to these registers, and further go writes, are ignored while a transfer is running.

Control is a four-state machine. IDLE waits for a go write. On a go write with a nonzero count it takes the *launch* transition to FETCH. On a go write with a zero count it takes the *empty start* self-loop, which stays in IDLE and raises the interrupt. FETCH holds a read request until it is granted (*granted*, to WAIT). WAIT holds until read data returns (*data back*, to SEND). SEND offers the byte until the transmitter takes it. It then goes back to FETCH (*next*) if bytes remain, or to IDLE (*finish*) after the last byte.

Top module: `txdma_engine`

## Requirements
- R1: After reset the interrupt is low, the busy bit is 0, and neither a memory request nor a transmit byte is offered.
- R2: Register offsets are as follows. Offset 0 holds the current address. Offset 1 holds the remaining count. Offset 2 is written to acknowledge and reads back status, with bit 0 = busy and bit 1 = interrupt pending. Offset 3 is written to start and reads back 0. Reads are combinational from reg_addr.
- R3: A start write with a nonzero count while idle makes busy read 1 from the next cycle on. The first read request carries the programmed address.
- R4: Each byte accepted by the transmitter adds 1 to the address, wrapping at the address width, and takes 1 from the count. A request keeps mem_addr stable until it is granted.
- R5: Bytes appear on tx_data in memory order, one per address. tx_data holds steady while tx_valid is high and tx_ready is low.
- R6: Only one read is in flight at a time. mem_req and tx_valid are never high together.
- R7: In the cycle after the last byte is accepted, busy is 0 and irq is 1.
- R8: A start write with a count of 0 while idle raises irq in the next cycle, issues no memory request and leaves busy at 0.
- R9: While busy, writes to offsets 0, 1 and 3 have no effect.
- R10: irq stays high until a write to offset 2, which clears it. If a completion happens in the same cycle as that write, the completion wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register offset for write and read |
| reg_wdata | input | REG_W | Register write data |
| reg_rdata | output | REG_W | Register read data for reg_addr |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | ADDR_W | Byte address of the request |
| mem_gnt | input | 1 | Request accepted this cycle |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | BYTE_W | Read data |
| tx_valid | output | 1 | Byte offered to transmitter |
| tx_data | output | BYTE_W | Byte to transmit |
| tx_ready | input | 1 | Transmitter takes the byte |
| irq | output | 1 | Completion interrupt, level |

## Verification
Several properties are checked on every cycle by assertions: a request holds its address until granted, and a byte holds until it is taken. A read request and a transmit offer never overlap. A pending interrupt holds until acknowledged. The registers stay frozen while busy except for stepping. An empty start completes at once. The bench's scenarios are needed to show the other behaviours: that bytes come out in memory order, that addresses wrap, that the exact count is delivered under grant and ready stalls with read latency, and the timing of busy and irq around the last byte. Its behavioural model is compared against the ports on every clock.

// File: rtl/txdma_pkg.sv
package txdma_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_WAIT,
        ST_SEND
    } txdma_state_e;

    localparam logic [1:0] OFS_ADDR  = 2'd0;
    localparam logic [1:0] OFS_COUNT = 2'd1;
    localparam logic [1:0] OFS_CTRL  = 2'd2;
    localparam logic [1:0] OFS_GO    = 2'd3;
endpackage

// File: rtl/txdma_regs.sv
module txdma_regs
    import txdma_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16,
    parameter int REG_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        ofs,
    input  logic [REG_W-1:0]  wr_data,
    input  logic              busy,
    input  logic              step,
    input  logic              done,
    output logic [REG_W-1:0]  rd_data,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              go,
    output logic              cnt_zero,
    output logic              cnt_last,
    output logic              irq
);
    logic [ADDR_W-1:0] base_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              irq_q;
    logic              ack_wr;

    assign ack_wr   = wr_en && (ofs == OFS_CTRL);
    assign go       = wr_en && (ofs == OFS_GO) && !busy;
    assign cnt_zero = (cnt_q == '0);
    assign cnt_last = (cnt_q == CNT_W'(1));
    assign cur_addr = base_q;
    assign irq      = irq_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            cnt_q  <= '0;
            irq_q  <= 1'b0;
        end else begin
            if (step) begin
                base_q <= base_q + ADDR_W'(1);
                cnt_q  <= cnt_q - CNT_W'(1);
            end else if (wr_en && !busy) begin
                if (ofs == OFS_ADDR)  base_q <= wr_data[ADDR_W-1:0];
                if (ofs == OFS_COUNT) cnt_q  <= wr_data[CNT_W-1:0];
            end
            if (done)        irq_q <= 1'b1;
            else if (ack_wr) irq_q <= 1'b0;
        end
    end

    always_comb begin
        unique case (ofs)
            OFS_ADDR:  rd_data = REG_W'(base_q);
            OFS_COUNT: rd_data = REG_W'(cnt_q);
            OFS_CTRL:  rd_data = REG_W'({irq_q, busy});
            default:   rd_data = '0;
        endcase
    end

    // R10: a pending interrupt survives until acknowledged
    p_irq_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q && !ack_wr |=> irq_q);

    // R9: software cannot disturb address or count during a transfer
    p_locked_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !step |=> $stable(base_q) && $stable(cnt_q));
endmodule

// File: rtl/txdma_fsm.sv
module txdma_fsm
    import txdma_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic              cnt_zero,
    input  logic              cnt_last,
    input  logic              mem_gnt,
    input  logic              mem_rvalid,
    input  logic [BYTE_W-1:0] mem_rdata,
    input  logic              tx_ready,
    output logic              busy,
    output logic              step,
    output logic              done,
    output logic              mem_req,
    output logic              tx_valid,
    output logic [BYTE_W-1:0] tx_data
);
    txdma_state_e state_q, state_d;
    logic [BYTE_W-1:0] byte_q;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                                byte_q <= '0;
        else if (state_q == ST_WAIT && mem_rvalid) byte_q <= mem_rdata;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (go && !cnt_zero) state_d = ST_FETCH;
            ST_FETCH: if (mem_gnt)         state_d = ST_WAIT;
            ST_WAIT:  if (mem_rvalid)      state_d = ST_SEND;
            ST_SEND:  if (tx_ready)        state_d = cnt_last ? ST_IDLE : ST_FETCH;
        endcase
    end

    always_comb begin
        busy     = (state_q != ST_IDLE);
        mem_req  = (state_q == ST_FETCH);
        tx_valid = (state_q == ST_SEND);
        tx_data  = byte_q;
        step     = (state_q == ST_SEND) && tx_ready;
        done     = ((state_q == ST_IDLE) && go && cnt_zero) ||
                   ((state_q == ST_SEND) && tx_ready && cnt_last);
    end

    // R5: an offered byte stays put until taken
    p_tx_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));

    // R6: never a request while a byte is still waiting for the transmitter
    p_one_in_flight_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_req && tx_valid));
endmodule

// File: rtl/txdma_engine.sv
module txdma_engine
    import txdma_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16,
    parameter int REG_W  = 16,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_gnt,
    input  logic              mem_rvalid,
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic              tx_valid,
    output logic [BYTE_W-1:0] tx_data,
    input  logic              tx_ready,
    output logic              irq
);
    logic busy, step, done, go, cnt_zero, cnt_last;

    txdma_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .REG_W(REG_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .ofs(reg_addr),
        .wr_data(reg_wdata), .busy(busy), .step(step), .done(done),
        .rd_data(reg_rdata), .cur_addr(mem_addr), .go(go),
        .cnt_zero(cnt_zero), .cnt_last(cnt_last), .irq(irq)
    );

    txdma_fsm #(.BYTE_W(BYTE_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .go(go), .cnt_zero(cnt_zero),
        .cnt_last(cnt_last), .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata), .tx_ready(tx_ready), .busy(busy),
        .step(step), .done(done), .mem_req(mem_req),
        .tx_valid(tx_valid), .tx_data(tx_data)
    );

    // R4: request address held until grant
    p_req_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_gnt |=> mem_req && $stable(mem_addr));

    // R8: empty start completes at once without touching memory
    p_empty_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr && reg_addr == OFS_GO && !busy && cnt_zero |=> irq && !mem_req && !busy);
endmodule

// File: tb/txdma_engine_tb.sv
module txdma_engine_tb;
    localparam int AW = 16;
    localparam int CW = 16;
    localparam int RW = 16;
    localparam int BW = 8;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst_n;
    logic          reg_wr;
    logic [1:0]    reg_addr;
    logic [RW-1:0] reg_wdata;
    logic [RW-1:0] reg_rdata;
    logic          mem_req;
    logic [AW-1:0] mem_addr;
    logic          mem_gnt;
    logic          mem_rvalid;
    logic [BW-1:0] mem_rdata;
    logic          tx_valid;
    logic [BW-1:0] tx_data;
    logic          tx_ready;
    logic          irq;

    txdma_engine #(.ADDR_W(AW), .CNT_W(CW), .REG_W(RW), .BYTE_W(BW)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_ready(tx_ready), .irq(irq)
    );

    int n_chk = 0;
    int n_fail = 0;

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [BW-1:0] mem_byte(input logic [AW-1:0] a);
        return a[7:0] ^ a[15:8] ^ 8'hA5;
    endfunction

    // behavioural reference state
    logic [AW-1:0] m_addr = '0;
    logic [CW-1:0] m_cnt  = '0;
    bit   m_busy = 0, m_irq = 0;
    int   tx_seen = 0;
    bit   hs_mem = 0;
    logic [AW-1:0] hs_addr = '0;
    bit   stall = 0;
    int   rd_lat = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            bit set_i, clr_i;
            set_i = 0; clr_i = 0;
            check(irq === m_irq, "R7/R10 irq level", irq, m_irq);
            check(!(mem_req && tx_valid), "R6 request with byte pending", mem_req, 0);
            if (!m_busy) check(!mem_req && !tx_valid, "R8 idle engine quiet", {mem_req, tx_valid}, 0);
            if (mem_req) check(mem_addr === m_addr, "R3 R4 request address", mem_addr, m_addr);
            if (!reg_wr) begin
                case (reg_addr)
                    2'd0: check(reg_rdata === m_addr, "R2 address readback", reg_rdata, m_addr);
                    2'd1: check(reg_rdata === m_cnt, "R2 count readback", reg_rdata, m_cnt);
                    2'd2: check(reg_rdata === RW'({m_irq, m_busy}), "R2 R3 status readback",
                                reg_rdata, {m_irq, m_busy});
                    default: check(reg_rdata === '0, "R2 go readback", reg_rdata, 0);
                endcase
            end
            hs_mem  = mem_req && mem_gnt;
            hs_addr = mem_addr;
            if (tx_valid && tx_ready) begin
                check(tx_data === mem_byte(m_addr), "R5 byte order", tx_data, mem_byte(m_addr));
                tx_seen++;
                if (m_cnt == 1) begin m_busy = 0; set_i = 1; end
                m_addr = m_addr + 1'b1;
                m_cnt  = m_cnt - 1'b1;
            end
            if (reg_wr) begin
                case (reg_addr)
                    2'd0: if (!m_busy) m_addr = reg_wdata;
                    2'd1: if (!m_busy) m_cnt = reg_wdata;
                    2'd2: clr_i = 1;
                    default: if (!m_busy) begin
                        if (m_cnt == 0) set_i = 1; else m_busy = 1;
                    end
                endcase
            end
            if (set_i)      m_irq = 1;
            else if (clr_i) m_irq = 0;
        end
    end

    // memory and transmitter responder
    initial begin
        int cyc, lat;
        bit pend;
        logic [AW-1:0] pend_addr;
        cyc = 0; lat = 0; pend = 0; pend_addr = '0;
        mem_gnt = 0; mem_rvalid = 0; mem_rdata = '0; tx_ready = 0;
        forever begin
            @(posedge clk); #1;
            cyc++;
            mem_rvalid = 0;
            if (hs_mem) begin pend = 1; pend_addr = hs_addr; lat = rd_lat; end
            if (pend) begin
                if (lat == 0) begin
                    mem_rvalid = 1; mem_rdata = mem_byte(pend_addr); pend = 0;
                end else lat--;
            end
            mem_gnt  = mem_req && (stall ? (cyc % 3 == 0) : 1'b1);
            tx_ready = stall ? (cyc % 2 == 0) : 1'b1;
        end
    end

    task automatic wr(input logic [1:0] a, input logic [RW-1:0] d);
        @(posedge clk); #1;
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 0; reg_addr = 2'd2; reg_wdata = '0;
    endtask

    task automatic launch(input logic [AW-1:0] b, input logic [CW-1:0] n);
        wr(2'd0, b); wr(2'd1, n); wr(2'd2, '0); wr(2'd3, '0);
    endtask

    task automatic wait_irq(input int lim);
        for (int i = 0; i < lim; i++) begin
            @(negedge clk);
            if (irq) break;
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        int base_seen;
        rst_n = 0; reg_wr = 0; reg_addr = 2'd2; reg_wdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(!irq && !mem_req && !tx_valid, "R1 reset outputs", {irq, mem_req, tx_valid}, 0);
        check(reg_rdata === '0, "R1 reset status", reg_rdata, 0);
        @(posedge clk); #1; rst_n = 1;

        // R3 R4 R7: plain four-byte transfer
        base_seen = tx_seen;
        launch(16'h0040, 16'd4);
        wait_irq(200);
        check(tx_seen - base_seen == 4, "R7 bytes delivered", tx_seen - base_seen, 4);
        @(posedge clk); #1; reg_addr = 2'd0;
        @(negedge clk);
        check(reg_rdata === 16'h0044, "R4 final address", reg_rdata, 16'h0044);

        // R4 R5: stalls and read latency across a byte boundary
        stall = 1; rd_lat = 2;
        base_seen = tx_seen;
        launch(16'h00FE, 16'd5);
        wait_irq(400);
        check(tx_seen - base_seen == 5, "R5 bytes under stalls", tx_seen - base_seen, 5);
        @(posedge clk); #1; reg_addr = 2'd0;
        @(negedge clk);
        check(reg_rdata === 16'h0103, "R4 address after stalls", reg_rdata, 16'h0103);
        stall = 0; rd_lat = 0;

        // R8: empty start
        base_seen = tx_seen;
        launch(16'h0300, 16'd0);
        @(negedge clk);
        check(irq === 1'b1, "R8 empty start interrupt", irq, 1);
        check(tx_seen == base_seen, "R8 no bytes on empty start", tx_seen - base_seen, 0);

        // R9: writes while busy
        base_seen = tx_seen;
        stall = 1;
        launch(16'h0200, 16'd6);
        wr(2'd0, 16'h1234); wr(2'd1, 16'd1); wr(2'd3, '0);
        wait_irq(400);
        check(tx_seen - base_seen == 6, "R9 count unaffected by busy writes", tx_seen - base_seen, 6);
        @(posedge clk); #1; reg_addr = 2'd0;
        @(negedge clk);
        check(reg_rdata === 16'h0206, "R9 address unaffected by busy writes", reg_rdata, 16'h0206);
        stall = 0;

        // R10: interrupt holds until acknowledged
        repeat (20) @(negedge clk);
        check(irq === 1'b1, "R10 interrupt held", irq, 1);
        wr(2'd2, 16'h0000);
        @(negedge clk);
        check(irq === 1'b0, "R10 acknowledge clears", irq, 0);

        // R4: single byte with address wrap
        base_seen = tx_seen;
        launch(16'hFFFF, 16'd1);
        wait_irq(200);
        check(tx_seen - base_seen == 1, "R7 single byte", tx_seen - base_seen, 1);
        @(posedge clk); #1; reg_addr = 2'd0;
        @(negedge clk);
        check(reg_rdata === 16'h0000, "R4 address wrap", reg_rdata, 0);
        @(posedge clk); #1; reg_addr = 2'd1;
        @(negedge clk);
        check(reg_rdata === 16'h0000, "R4 count exhausted", reg_rdata, 0);

        repeat (5) @(negedge clk);
        finish_run();
    end
endmodule